// File: doc/BRIEF.md
# Dual-Digit Hit Display Controller

This block watches a word of target sensor inputs and shows the number of the sensor that was struck on a two-digit seven-segment display. The display sits behind two serial-in, parallel-out shift registers that each have an output latch. The block encodes the lowest active sensor into a digit and converts the digit to a segment byte. It then serializes the left and right digit bytes at the same time on two data lines that share one shift clock, and it finishes each update with a single pulse on a shared storage clock.

After reset the block writes zero to both digits and holds the display on for four delay periods. It then blinks the display twice by driving the active-low output enable. From then on the left digit stays at zero and the right digit shows the most recent hit. A sensor word with no active sensor leaves the display untouched. All timing is counted in prescaled ticks: `TICK_DIV` clocks make one tick, and one delay period is `BLINK_TICKS` ticks.

Top module: `hitDisplayTop`

## Requirements
- R1: Bits 0 and 1 of `sensorWord` are ignored. A word with only those bits set starts no transfer.
- R2: When bits 2 to 7 are all zero, no shift or storage pulse occurs and the latched display keeps its last value.
- R3: The lowest set bit among bits 2 to 7 selects the digit. Bit k gives digit k-1, so bit 2 gives 1 and bit 7 gives 6.
- R4: After start-up every transfer puts digit 0 in the left register and the hit digit in the right register.
- R5: Each digit byte is {1'b0, code}, where code is 7 bits: 0=7B, 1=60, 2=37, 3=76, 4=6C, 5=5E, 6=5F, 7=70, 8=7F, 9=7E (hex).
- R6: A transfer shifts 8 bits MSB first. Left bits go on `dataLeft` and right bits on `dataRight`. Each bit pair is clocked by one `shiftClk` pulse that is one tick high. The data is stable for one tick before the rising edge and throughout the high time.
- R7: Exactly one `storeClk` pulse, one tick high, follows the eighth shift pulse. `storeClk` and `shiftClk` are never high together.
- R8: At start-up both digits are loaded with 0. After the storage pulse, `outEnN` stays low for 4 delay periods. It is then high, low and high for one period each, and then stays low.
- R9: A sensor change during a transfer is sampled only after that transfer's storage pulse has ended.
- R10: During reset, `shiftClk`, `storeClk`, `dataLeft`, `dataRight` and `outEnN` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sensorWord | input | 8 | Sensor inputs, active high, sensors on bits 2..7 |
| dataLeft | output | 1 | Serial data for the left-digit shift register |
| dataRight | output | 1 | Serial data for the right-digit shift register |
| shiftClk | output | 1 | Shared shift clock |
| storeClk | output | 1 | Shared storage (latch) clock |
| outEnN | output | 1 | Display output enable, active low |

## Verification
The assertions check on every cycle that the two clocks never overlap, that the data lines hold still across each shift-clock rise and high time, that exactly eight shift pulses come before each storage pulse, and that the display is never blanked during a transfer. Only the bench scenarios can show what the display actually shows. The bench feeds the serial lines into a behavioural model of the two shift registers and compares the latched bytes with the expected segment codes, covering priority between several active sensors, the ignored low bits, a hit that changes in the middle of a transfer, and the length of each blink phase.

// File: rtl/hitDisplayPkg.sv
package hitDisplayPkg;

  localparam int SEG_W = 8;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    X_IDLE,
    X_SETUP,
    X_CLKHI,
    X_STORE
  } xferState_t;

  typedef enum logic [2:0] {
    P_BOOT,
    P_SHOW,
    P_OFF1,
    P_ON1,
    P_OFF2,
    P_RUN
  } phase_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic loadBoot;
    logic loadHit;
    logic shift;
  } pathCmd_t;

  // segment byte, MSB always 0, low 7 bits in register order
  function automatic logic [SEG_W-1:0] segByte(input logic [DIGIT_W-1:0] digit);
    logic [SEG_W-1:0] s;
    case (digit)
      4'd0: s = 8'h7B;
      4'd1: s = 8'h60;
      4'd2: s = 8'h37;
      4'd3: s = 8'h76;
      4'd4: s = 8'h6C;
      4'd5: s = 8'h5E;
      4'd6: s = 8'h5F;
      4'd7: s = 8'h70;
      4'd8: s = 8'h7F;
      4'd9: s = 8'h7E;
      default: s = 8'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hitDisplayPath.sv
module hitDisplayPath
  import hitDisplayPkg::*;
#(
  parameter int SENSE_W = 8,
  parameter int FIRST_SENSOR = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pathCmd_t           cmd,
  input  logic [SENSE_W-1:0] sensorWord,
  output logic               hitValid,
  output logic               dataLeft,
  output logic               dataRight
);

  localparam logic [SENSE_W-1:0] SENSE_MASK = ~SENSE_W'((1 << FIRST_SENSOR) - 1);

  logic [SENSE_W-1:0] masked;
  logic [DIGIT_W-1:0] hitDigit;
  logic [SEG_W-1:0]   leftSr, rightSr;

  assign masked   = sensorWord & SENSE_MASK;
  assign hitValid = |masked;

  // lowest active sensor wins: scan downward so the last match is lowest
  always_comb begin
    hitDigit = '0;
    for (int i = SENSE_W - 1; i >= FIRST_SENSOR; i--) begin
      if (masked[i]) hitDigit = DIGIT_W'(i - FIRST_SENSOR + 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftSr  <= '0;
      rightSr <= '0;
    end else if (cmd.loadBoot) begin
      leftSr  <= segByte('0);
      rightSr <= segByte('0);
    end else if (cmd.loadHit) begin
      leftSr  <= segByte('0);
      rightSr <= segByte(hitDigit);
    end else if (cmd.shift) begin
      leftSr  <= {leftSr[SEG_W-2:0], 1'b0};
      rightSr <= {rightSr[SEG_W-2:0], 1'b0};
    end
  end

  assign dataLeft  = leftSr[SEG_W-1];
  assign dataRight = rightSr[SEG_W-1];

endmodule

// File: rtl/hitDisplayCtrl.sv
module hitDisplayCtrl
  import hitDisplayPkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int BLINK_TICKS = 8,
  parameter int SHOW_PERIODS = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hitValid,
  output pathCmd_t cmd,
  output logic     shiftClk,
  output logic     storeClk,
  output logic     outEnN
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(TICK_DIV - 1);
  localparam int SHOW_LEN = SHOW_PERIODS * BLINK_TICKS;
  localparam int CW = $clog2(SHOW_LEN + 1);
  localparam int BW = $clog2(SEG_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(SEG_W - 1);

  logic [PW-1:0] preCnt;
  logic          tick;
  xferState_t    xfer;
  phase_t        phase;
  logic [BW-1:0] bitCnt;
  logic [CW-1:0] periodCnt, periodLimit;
  logic          timedPhase;

  generate
    if (TICK_DIV > 1) begin : g_pre
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PRE_MAX) preCnt <= '0;
        else preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_MAX);
    end else begin : g_nopre
      assign preCnt = '0;
      assign tick = 1'b1;
    end
  endgenerate

  assign timedPhase  = (phase == P_SHOW) || (phase == P_OFF1) ||
                       (phase == P_ON1)  || (phase == P_OFF2);
  assign periodLimit = (phase == P_SHOW) ? CW'(SHOW_LEN) : CW'(BLINK_TICKS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xfer      <= X_IDLE;
      phase     <= P_BOOT;
      bitCnt    <= '0;
      periodCnt <= '0;
    end else if (tick) begin
      case (xfer)
        X_IDLE: begin
          bitCnt <= '0;
          if (phase == P_BOOT || (phase == P_RUN && hitValid)) xfer <= X_SETUP;
        end
        X_SETUP: xfer <= X_CLKHI;
        X_CLKHI: begin
          if (bitCnt == LAST_BIT) xfer <= X_STORE;
          else begin
            xfer   <= X_SETUP;
            bitCnt <= bitCnt + 1'b1;
          end
        end
        X_STORE: xfer <= X_IDLE;
        default: xfer <= X_IDLE;
      endcase

      if (xfer == X_STORE && phase == P_BOOT) begin
        phase     <= P_SHOW;
        periodCnt <= '0;
      end else if (timedPhase) begin
        if (periodCnt == periodLimit - 1'b1) begin
          periodCnt <= '0;
          case (phase)
            P_SHOW:  phase <= P_OFF1;
            P_OFF1:  phase <= P_ON1;
            P_ON1:   phase <= P_OFF2;
            default: phase <= P_RUN;
          endcase
        end else begin
          periodCnt <= periodCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd          = '0;
    cmd.loadBoot = tick && xfer == X_IDLE && phase == P_BOOT;
    cmd.loadHit  = tick && xfer == X_IDLE && phase == P_RUN && hitValid;
    cmd.shift    = tick && xfer == X_CLKHI;
  end

  assign shiftClk = (xfer == X_CLKHI);
  assign storeClk = (xfer == X_STORE);
  assign outEnN   = (phase == P_OFF1) || (phase == P_OFF2);

endmodule

// File: rtl/hitDisplayTop.sv
module hitDisplayTop
  import hitDisplayPkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int BLINK_TICKS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] sensorWord,
  output logic       dataLeft,
  output logic       dataRight,
  output logic       shiftClk,
  output logic       storeClk,
  output logic       outEnN
);

  pathCmd_t cmd;
  logic     hitValid;

  hitDisplayCtrl #(
    .TICK_DIV(TICK_DIV),
    .BLINK_TICKS(BLINK_TICKS),
    .SHOW_PERIODS(4)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .hitValid(hitValid),
    .cmd(cmd),
    .shiftClk(shiftClk),
    .storeClk(storeClk),
    .outEnN(outEnN)
  );

  hitDisplayPath #(
    .SENSE_W(8),
    .FIRST_SENSOR(2)
  ) path_i (
    .clk(clk),
    .rstN(rstN),
    .cmd(cmd),
    .sensorWord(sensorWord),
    .hitValid(hitValid),
    .dataLeft(dataLeft),
    .dataRight(dataRight)
  );

endmodule

// File: rtl/hitDisplayChecker.sv
module hitDisplayChecker #(
  parameter int BITS = 8
) (
  input logic clk,
  input logic rstN,
  input logic dataLeft,
  input logic dataRight,
  input logic shiftClk,
  input logic storeClk,
  input logic outEnN
);

  logic       prevShift, prevStore;
  logic [7:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevShift <= 1'b0;
      prevStore <= 1'b0;
      pulseCnt  <= '0;
    end else begin
      prevShift <= shiftClk;
      prevStore <= storeClk;
      if (storeClk && !prevStore) pulseCnt <= '0;
      else if (shiftClk && !prevShift) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // R7: the two clocks are never high together
  assert_clk_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftClk && storeClk));

  // R6: data is settled when the shift clock rises
  assert_setup_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> ($stable(dataLeft) && $stable(dataRight)));

  // R6: data is held while the shift clock is high
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> ($stable(dataLeft) && $stable(dataRight)));

  // R7: storage pulse only after a full byte of shift pulses
  assert_store_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (storeClk && !prevStore) |-> (pulseCnt == 8'(BITS)));

  // R8: the display is never blanked while a transfer is under way
  assert_blank_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!shiftClk && !storeClk));

endmodule

bind hitDisplayTop hitDisplayChecker #(.BITS(8)) chk_i (
  .clk(clk),
  .rstN(rstN),
  .dataLeft(dataLeft),
  .dataRight(dataRight),
  .shiftClk(shiftClk),
  .storeClk(storeClk),
  .outEnN(outEnN)
);

// File: tb/hitDisplayTop_tb_top.sv
module hitDisplayTop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int BT = 8;
  localparam int PERIOD = TD * BT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sensorWord = '0;
  logic       dataLeft, dataRight, shiftClk, storeClk, outEnN;

  int vectors = 0;
  int misses = 0;
  int cycle = 0;
  int shiftRises = 0;
  logic [7:0] srL = '0, srR = '0, shownL = '0, shownR = '0;
  logic prevShiftN = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  hitDisplayTop #(.TICK_DIV(TD), .BLINK_TICKS(BT)) dut_i (
    .clk(clk), .rstN(rstN), .sensorWord(sensorWord),
    .dataLeft(dataLeft), .dataRight(dataRight),
    .shiftClk(shiftClk), .storeClk(storeClk), .outEnN(outEnN)
  );

  // behavioural model of the two shift register chips with latches
  always @(posedge shiftClk) begin
    srL <= {srL[6:0], dataLeft};
    srR <= {srR[6:0], dataRight};
  end
  always @(posedge storeClk) begin
    shownL <= srL;
    shownR <= srR;
  end

  function automatic logic [7:0] expSeg(input int d);
    case (d)
      0: return 8'h7B; 1: return 8'h60; 2: return 8'h37; 3: return 8'h76;
      4: return 8'h6C; 5: return 8'h5E; 6: return 8'h5F; 7: return 8'h70;
      8: return 8'h7F; 9: return 8'h7E; default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of output relations after reset
  always @(negedge clk) begin
    if (rstN) begin
      chk(!(shiftClk && storeClk), "R7 clock overlap", {30'd0, shiftClk, storeClk}, 0);
      if (outEnN) chk(!shiftClk && !storeClk, "R8 blank during transfer",
                      {30'd0, shiftClk, storeClk}, 0);
      if (shiftClk && !prevShiftN) shiftRises++;
    end
    prevShiftN <= shiftClk;
  end

  task automatic waitStore(output int fallCyc);
    int n = 0;
    fallCyc = -1;
    while (storeClk !== 1'b1 && n < 4000) begin @(negedge clk); n++; end
    while (storeClk !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk(0, "store pulse timeout", 0, 1);
    else fallCyc = cycle;
  endtask

  task automatic waitOe(input logic lvl, output int at);
    int n = 0;
    while (outEnN !== lvl && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk(0, "R8 enable timeout", 0, 1);
    at = cycle;
  endtask

  task automatic hitCase(input logic [7:0] w, input int digit, input string req);
    int t;
    @(negedge clk);
    sensorWord = w;
    waitStore(t);
    sensorWord = '0;
    chk(shownR == expSeg(digit), req, shownR, expSeg(digit));
    chk(shownL == expSeg(0), "R4 left digit zero", shownL, expSeg(0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    misses++;
    vectors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int tStore, tA, tB, tC, tD, r0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({shiftClk, storeClk, dataLeft, dataRight, outEnN} == 5'b0, "R10 reset outputs",
        {shiftClk, storeClk, dataLeft, dataRight, outEnN}, 0);
    rstN = 1'b1;

    // R8 boot load of zeros then blink timing
    waitStore(tStore);
    chk(shownL == 8'h7B, "R8 boot left zero", shownL, 8'h7B);
    chk(shownR == 8'h7B, "R8 boot right zero", shownR, 8'h7B);
    waitOe(1'b1, tA);
    chk(tA - tStore == 4 * PERIOD, "R8 show length", tA - tStore, 4 * PERIOD);
    waitOe(1'b0, tB);
    chk(tB - tA == PERIOD, "R8 first blank", tB - tA, PERIOD);
    waitOe(1'b1, tC);
    chk(tC - tB == PERIOD, "R8 first relit", tC - tB, PERIOD);
    waitOe(1'b0, tD);
    chk(tD - tC == PERIOD, "R8 second blank", tD - tC, PERIOD);
    repeat (3 * PERIOD) @(negedge clk);
    chk(outEnN == 1'b0, "R8 stays on", outEnN, 0);

    // R3 R5 R6 each single sensor
    for (int k = 2; k < 8; k++) hitCase(8'(1 << k), k - 1, "R3 R5 R6 single sensor digit");

    // R3 priority among several sensors
    hitCase(8'hA8, 2, "R3 lowest of several");
    hitCase(8'hFC, 1, "R3 all sensors");
    hitCase(8'hC3, 5, "R3 with low bits set");

    // R1 low bits ignored, R2 zero word holds display
    r0 = shiftRises;
    @(negedge clk); sensorWord = 8'h03;
    repeat (200) @(negedge clk);
    chk(shiftRises == r0, "R1 low bits start nothing", shiftRises - r0, 0);
    chk(shownR == expSeg(5), "R1 display unchanged", shownR, expSeg(5));
    sensorWord = 8'h00;
    repeat (200) @(negedge clk);
    chk(shiftRises == r0, "R2 zero word idle", shiftRises - r0, 0);
    chk(shownR == expSeg(5) && shownL == expSeg(0), "R2 display held", shownR, expSeg(5));

    // R9 change during a transfer
    @(negedge clk); sensorWord = 8'h80;
    while (shiftClk !== 1'b1) @(negedge clk);
    sensorWord = 8'h04;
    waitStore(tA);
    chk(shownR == expSeg(6), "R9 first transfer keeps sample", shownR, expSeg(6));
    r0 = shiftRises;
    waitStore(tB);
    sensorWord = 8'h00;
    chk(shownR == expSeg(1), "R9 new hit after store", shownR, expSeg(1));
    chk(shiftRises - r0 == 8, "R6 eight shift pulses", shiftRises - r0, 8);

    repeat (50) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule